// File: doc/BRIEF.md
# Message-Signaled Interrupt Address Composer

This block turns wired interrupt sources into message writes when the interrupt domain runs in message delivery mode. Software programs a pair of address configuration words and one target word per source. The pair holds a base page number, the widths and bit positions of the group, hart and guest index fields, and a lock bit. Each target word names a hart, a guest and an interrupt identity.

A source gateway supplies per-source pending and enable vectors. When message mode is on and at least one source is both pending and enabled, the block picks one of those sources. It builds a 64-bit write address and a 32-bit data word for that source and presents them on a valid/ready output. After the handshake it returns a one-cycle clear-pending pulse to the gateway for that source.

Top module: `msi_addr_composer`

## Requirements
- R1: While reset is asserted and right after it, `msg_valid` is 0 and `clr_pend` is all zeros. Every target word resets to zero.
- R2: A target word is decoded as follows:
  - hart index in bits 31:18;
  - guest index in bits 17:12;
  - interrupt identity in bits 10:0, with bit 11 ignored.
  The message data is the identity, zero-extended to 32 bits.
- R3: The configuration words are laid out as follows:
  - `cfg_sel`=0 selects the low word, which holds base page bits 31:0.
  - `cfg_sel`=1 selects the high word:
    - bit 31 is the lock;
    - bits 28:24 are the group shift S_G;
    - bits 22:20 are the guest width W_U;
    - bits 18:16 are the group width W_G;
    - bits 15:12 are the hart width W_H;
    - bits 11:0 are base page bits 43:32.

  The page number is the base, ORed with three fields:
  - the low W_U bits of the guest index, at bit 0;
  - the low W_H bits of the hart index, at bit W_U;
  - hart bits above W_H, W_G of them, at bit S_G+12.

  The address is the page number shifted left by 12. The address uses the configuration in force before any write made in the same cycle as the source is picked.
- R4: No message starts unless both `dom_msi_mode` and `dom_enable` are 1 in the cycle the source is picked.
- R5: Among sources that are both pending and enabled, the lowest index is sent first.
- R6: Once `msg_valid` rises, it stays high until `msg_ready` is seen. `msg_addr` and `msg_data` stay stable during that time, even if the configuration is rewritten.
- R7: The cycle after a handshake, `msg_valid` is 0 and `clr_pend` has exactly the chosen source's bit set, for one cycle only. A new message can start no earlier than two cycles after the handshake.
- R8: After a high-word write with bit 31 set, later writes to both configuration words are ignored until reset.
- R9: An all-zero target word still produces a message, with address equal to the base page number shifted left by 12 and data 0.
- R10: A source that is pending but not enabled is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 1 | 0 selects the low word, 1 selects the high word |
| cfg_wdata | input | 32 | Configuration write data |
| tgt_we | input | 1 | Target word write strobe |
| tgt_idx | input | SRC_W | Source whose target word is written |
| tgt_wdata | input | 32 | Target word write data |
| dom_msi_mode | input | 1 | Domain delivery mode is message mode |
| dom_enable | input | 1 | Domain global interrupt enable |
| src_pending | input | NSRC | Pending bits from the gateway |
| src_enable | input | NSRC | Enable bits from the gateway |
| msg_valid | output | 1 | Message write is presented |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |
| clr_pend | output | NSRC | One-cycle clear-pending pulse, one-hot |

## Verification
Two functions can land in the same clock edge: a configuration write and the pick of a source. The bench provokes this by raising a pending bit and a low-word write together at one negedge. It judges the result by expecting the first message to carry the old base and a second message from the same source to carry the new base. A related overlap is a configuration write made while a message is held unaccepted. There the bench expects the held address and data to stay unchanged.

// File: rtl/msi_enc_pkg.sv
package msi_enc_pkg;
  localparam int PPN_W      = 44;
  localparam int ADDR_W     = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int HART_W     = 14;
  localparam int GUEST_W    = 6;
  localparam int EIID_W     = 11;

  typedef struct packed {
    logic        lock;
    logic [4:0]  grp_shift;
    logic [2:0]  guest_w;
    logic [2:0]  grp_w;
    logic [3:0]  hart_w;
    logic [11:0] base_hi;
  } addr_cfg_t;

  typedef struct packed {
    logic [HART_W-1:0]  hart;
    logic [GUEST_W-1:0] guest;
    logic [EIID_W-1:0]  eiid;
  } tgt_t;

  function automatic addr_cfg_t unpack_hi(input logic [31:0] w);
    addr_cfg_t c;
    c.lock      = w[31];
    c.grp_shift = w[28:24];
    c.guest_w   = w[22:20];
    c.grp_w     = w[18:16];
    c.hart_w    = w[15:12];
    c.base_hi   = w[11:0];
    return c;
  endfunction

  function automatic tgt_t unpack_tgt(input logic [31:0] w);
    tgt_t t;
    t.hart  = w[31:18];
    t.guest = w[17:12];
    t.eiid  = w[10:0];
    return t;
  endfunction

  function automatic logic [PPN_W-1:0] low_ones(input logic [3:0] w);
    return (PPN_W'(1) << w) - PPN_W'(1);
  endfunction

  function automatic logic [PPN_W-1:0] compose_ppn(input logic [31:0] lo,
                                                   input addr_cfg_t c,
                                                   input tgt_t t);
    logic [PPN_W-1:0] base, gst, hlo, grp;
    base = {c.base_hi, lo};
    gst  = PPN_W'(t.guest) & low_ones({1'b0, c.guest_w});
    hlo  = (PPN_W'(t.hart) & low_ones(c.hart_w)) << c.guest_w;
    grp  = ((PPN_W'(t.hart) >> c.hart_w) & low_ones({1'b0, c.grp_w}))
           << ({1'b0, c.grp_shift} + 6'd12);
    return base | gst | hlo | grp;
  endfunction

  function automatic logic [ADDR_W-1:0] compose_addr(input logic [31:0] lo,
                                                     input addr_cfg_t c,
                                                     input tgt_t t);
    return {{(ADDR_W-PPN_W-PAGE_SHIFT){1'b0}}, compose_ppn(lo, c, t),
            {PAGE_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_lo_q,
  output addr_cfg_t   cfg_hi_q,
  output logic        cfg_lock
);
  logic wr_lo, wr_hi;

  assign cfg_lock = cfg_hi_q.lock;
  assign wr_lo    = cfg_we && !cfg_sel && !cfg_lock;
  assign wr_hi    = cfg_we &&  cfg_sel && !cfg_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_lo_q <= '0;
    else if (wr_lo) cfg_lo_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_hi_q <= '0;
    else if (wr_hi) cfg_hi_q <= unpack_hi(cfg_wdata);
  end
endmodule

// File: rtl/msi_target_store.sv
module msi_target_store
  import msi_enc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_we,
  input  logic [SRC_W-1:0] tgt_idx,
  input  logic [31:0]      tgt_wdata,
  input  logic [SRC_W-1:0] rd_idx,
  output tgt_t             rd_tgt
);
  tgt_t slot_q [NSRC];

  for (genvar s = 0; s < NSRC; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (tgt_we && tgt_idx == SRC_W'(s))
        slot_q[s] <= unpack_tgt(tgt_wdata);
    end
  end

  assign rd_tgt = slot_q[rd_idx];
endmodule

// File: rtl/msi_issue.sv
module msi_issue
  import msi_enc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int SRC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_on,
  input  logic [NSRC-1:0]   req_vec,
  input  logic [31:0]       cfg_lo_q,
  input  addr_cfg_t         cfg_hi_q,
  input  tgt_t              pick_tgt,
  output logic [SRC_W-1:0]  pick_idx,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [31:0]       msg_data,
  output logic [NSRC-1:0]   clr_pend,
  output logic              launch,
  output logic              handshake
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_CLEAR} st_t;

  st_t              st_q;
  logic             pick_any;
  logic [SRC_W-1:0] sel_q;

  always_comb begin
    pick_idx = '0;
    pick_any = 1'b0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (req_vec[s]) begin
        pick_idx = SRC_W'(s);
        pick_any = 1'b1;
      end
    end
  end

  assign launch    = (st_q == ST_IDLE) && mode_on && pick_any;
  assign handshake = (st_q == ST_SEND) && msg_ready;
  assign msg_valid = (st_q == ST_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sel_q    <= '0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q     <= ST_SEND;
          sel_q    <= pick_idx;
          msg_addr <= compose_addr(cfg_lo_q, cfg_hi_q, pick_tgt);
          msg_data <= 32'(pick_tgt.eiid);
        end
        ST_SEND:  if (handshake) st_q <= ST_CLEAR;
        ST_CLEAR: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    clr_pend = '0;
    if (st_q == ST_CLEAR) clr_pend[sel_q] = 1'b1;
  end
endmodule

// File: rtl/msi_addr_composer.sv
module msi_addr_composer
  import msi_enc_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              tgt_we,
  input  logic [SRC_W-1:0]  tgt_idx,
  input  logic [31:0]       tgt_wdata,
  input  logic              dom_msi_mode,
  input  logic              dom_enable,
  input  logic [NSRC-1:0]   src_pending,
  input  logic [NSRC-1:0]   src_enable,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [31:0]       msg_data,
  output logic [NSRC-1:0]   clr_pend
);
  logic [31:0]      cfg_lo_q;
  addr_cfg_t        cfg_hi_q;
  logic             cfg_lock;
  logic             mode_on;
  logic [NSRC-1:0]  req_vec;
  logic [SRC_W-1:0] pick_idx;
  tgt_t             pick_tgt;
  logic             launch, handshake;

  assign mode_on = dom_msi_mode & dom_enable;
  assign req_vec = src_pending & src_enable;

  msi_cfg_regs u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .cfg_lo_q, .cfg_hi_q, .cfg_lock
  );

  msi_target_store #(.NSRC(NSRC), .SRC_W(SRC_W)) u_tgt (
    .clk, .rst_n, .tgt_we, .tgt_idx, .tgt_wdata,
    .rd_idx(pick_idx), .rd_tgt(pick_tgt)
  );

  msi_issue #(.NSRC(NSRC), .SRC_W(SRC_W)) u_issue (
    .clk, .rst_n, .mode_on, .req_vec, .cfg_lo_q, .cfg_hi_q, .pick_tgt,
    .pick_idx, .msg_ready, .msg_valid, .msg_addr, .msg_data, .clr_pend,
    .launch, .handshake
  );
endmodule

// File: rtl/msi_addr_composer_chk.sv
module msi_addr_composer_chk
  import msi_enc_pkg::*;
#(
  parameter int NSRC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dom_msi_mode,
  input logic              dom_enable,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [31:0]       msg_data,
  input logic [NSRC-1:0]   clr_pend,
  input logic              cfg_lock,
  input logic [31:0]       cfg_lo_q,
  input addr_cfg_t         cfg_hi_q,
  input logic              launch,
  input logic              handshake
);
  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(dom_msi_mode && dom_enable));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_clr_after_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid && ($countones(clr_pend) == 1));

  p_clr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend != '0) |-> $past(handshake));

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_pend));

  p_no_launch_in_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend != '0) |-> !launch);

  p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> cfg_lock && $stable(cfg_lo_q) && $stable(cfg_hi_q));
endmodule

bind msi_addr_composer msi_addr_composer_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dom_msi_mode(dom_msi_mode), .dom_enable(dom_enable),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .clr_pend(clr_pend), .cfg_lock(cfg_lock),
  .cfg_lo_q(cfg_lo_q), .cfg_hi_q(cfg_hi_q), .launch(launch), .handshake(handshake)
);

// File: tb/msi_addr_composer_bench.sv
module msi_addr_composer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int SRC_W = 3;
  localparam int NVEC = 5;

  // each entry: {low word, high word, target word}
  localparam logic [95:0] VEC [NVEC] = '{
    {32'h0004_0000, 32'h0000_0000, (32'd5 << 18) | (32'd3 << 12) | 32'h02A},
    {32'h8000_0000, (32'd8 << 24) | (32'd3 << 20) | (32'd2 << 16) | (32'd4 << 12) | 32'h001,
     (32'h35 << 18) | (32'd5 << 12) | 32'h7FF},
    {32'h0000_0000, (32'd31 << 24) | (32'd7 << 20) | (32'd7 << 16) | (32'd15 << 12) | 32'hFFF,
     (32'h3FFF << 18) | (32'h3F << 12) | 32'h001},
    {32'h1234_0000, (32'd2 << 24) | (32'd0 << 20) | (32'd3 << 16) | (32'd2 << 12),
     (32'h1F << 18) | (32'h3F << 12) | 32'h100},
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0FFF}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic             tgt_we = 1'b0;
  logic [SRC_W-1:0] tgt_idx = '0;
  logic [31:0]      tgt_wdata = '0;
  logic             dom_msi_mode = 1'b0, dom_enable = 1'b0;
  logic [NSRC-1:0]  pend = '0, src_enable = '0;
  logic             msg_valid, msg_ready = 1'b0;
  logic [63:0]      msg_addr;
  logic [31:0]      msg_data;
  logic [NSRC-1:0]  clr_pend;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] cur_lo = '0, cur_hi = '0;
  logic [31:0] tmem [NSRC];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_addr_composer #(.NSRC(NSRC)) u_msi_addr_composer (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .tgt_we, .tgt_idx, .tgt_wdata,
    .dom_msi_mode, .dom_enable, .src_pending(pend), .src_enable,
    .msg_valid, .msg_ready, .msg_addr, .msg_data, .clr_pend
  );

  function automatic logic [63:0] exp_addr(input logic [31:0] lo, hi, tw);
    int wu, wh, wg, sg, j, k;
    logic [13:0] hart;
    logic [5:0]  guest;
    logic [43:0] p;
    wu = int'(hi[22:20]); wh = int'(hi[15:12]);
    wg = int'(hi[18:16]); sg = int'(hi[28:24]);
    hart = tw[31:18]; guest = tw[17:12];
    p = {hi[11:0], lo};
    for (int i = 0; i < 44; i++) begin
      if (i < wu && i < 6) p[i] = p[i] | guest[i];
      j = i - wu;
      if (j >= 0 && j < wh && j < 14) p[i] = p[i] | hart[j];
      k = i - (sg + 12);
      if (k >= 0 && k < wg && (wh + k) < 14) p[i] = p[i] | hart[wh + k];
    end
    return {8'h00, p, 12'h000};
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] tw);
    return {21'b0, tw[10:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr_cfg(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_tgt(input int idx, input logic [31:0] d);
    @(negedge clk); tgt_we = 1'b1; tgt_idx = SRC_W'(idx); tgt_wdata = d;
    @(negedge clk); tgt_we = 1'b0;
    tmem[idx] = d;
  endtask

  task automatic expect_valid(input string tag);
    @(negedge clk);
    chk(tag, 64'(msg_valid), 64'd1);
  endtask

  task automatic take_msg(input int src, input logic [63:0] ea, input logic [31:0] ed,
                          input string tag);
    chk({tag, " addr"}, msg_addr, ea);
    chk({tag, " data"}, 64'(msg_data), 64'(ed));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk("R7 clear pulse", 64'(clr_pend), 64'(1) << src);
    chk("R7 valid low after handshake", 64'(msg_valid), 64'd0);
    pend[src] = 1'b0;
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(clr_pend), 64'd0);
  endtask

  task automatic quiet(input int n, input string tag);
    logic seen;
    seen = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      seen = seen | msg_valid;
    end
    chk(tag, 64'(seen), 64'd0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [63:0] held_a, a1;
    logic [31:0] held_d, lo_old, lo_new, hi_lk, tw3;
    for (int s = 0; s < NSRC; s++) tmem[s] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(msg_valid), 64'd0);
    chk("R1 clr in reset", 64'(clr_pend), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 64'(msg_valid), 64'd0);
    dom_msi_mode = 1'b1; dom_enable = 1'b1; src_enable = '1;

    // R2 R3 table of configurations and targets on source 3
    for (int v = 0; v < NVEC; v++) begin
      cur_lo = VEC[v][95:64]; cur_hi = VEC[v][63:32];
      wr_cfg(1'b0, cur_lo);
      wr_cfg(1'b1, cur_hi);
      wr_tgt(3, VEC[v][31:0]);
      pend[3] = 1'b1;
      expect_valid("R3 vector valid");
      take_msg(3, exp_addr(cur_lo, cur_hi, tmem[3]), exp_data(tmem[3]), "R2 R3 vector");
    end

    // R9 zero target on source 0
    cur_lo = 32'h00AB_C000; cur_hi = (32'd3 << 20) | (32'd2 << 12) | 32'h005;
    wr_cfg(1'b0, cur_lo);
    wr_cfg(1'b1, cur_hi);
    pend[0] = 1'b1;
    expect_valid("R9 zero target valid");
    take_msg(0, {8'h00, 12'h005, 32'h00AB_C000, 12'h000}, 32'h0, "R9 zero target");

    // R5 ascending order
    wr_tgt(2, 32'h2); wr_tgt(5, 32'h5); wr_tgt(6, 32'h6);
    @(negedge clk);
    pend[5] = 1'b1; pend[2] = 1'b1; pend[6] = 1'b1;
    expect_valid("R5 first valid");
    take_msg(2, exp_addr(cur_lo, cur_hi, tmem[2]), 32'h2, "R5 first lowest");
    expect_valid("R5 second valid");
    take_msg(5, exp_addr(cur_lo, cur_hi, tmem[5]), 32'h5, "R5 second");
    expect_valid("R5 third valid");
    take_msg(6, exp_addr(cur_lo, cur_hi, tmem[6]), 32'h6, "R5 third");

    // R10 disabled source
    src_enable = ~(8'h02);
    wr_tgt(1, (32'd9 << 18) | 32'h7);
    pend[1] = 1'b1;
    quiet(5, "R10 disabled source not sent");
    src_enable = '1;
    expect_valid("R10 sent once enabled");
    take_msg(1, exp_addr(cur_lo, cur_hi, tmem[1]), 32'h7, "R10 enabled");

    // R4 mode gating
    dom_msi_mode = 1'b0; dom_enable = 1'b1;
    pend[4] = 1'b1;
    quiet(4, "R4 mode bit clear");
    dom_msi_mode = 1'b1; dom_enable = 1'b0;
    quiet(4, "R4 enable bit clear");
    dom_enable = 1'b1;
    expect_valid("R4 both set");
    take_msg(4, exp_addr(cur_lo, cur_hi, 32'h0), 32'h0, "R4 message");

    // R6 hold while not ready, with a configuration write in between
    wr_tgt(7, (32'h12 << 18) | (32'd1 << 12) | 32'h055);
    pend[7] = 1'b1;
    expect_valid("R6 valid");
    held_a = msg_addr; held_d = msg_data;
    chk("R6 addr at launch", held_a, exp_addr(cur_lo, cur_hi, tmem[7]));
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'hFFFF_0000;
    @(negedge clk); cfg_we = 1'b0;
    cur_lo = 32'hFFFF_0000;
    repeat (2) @(negedge clk);
    chk("R6 valid held", 64'(msg_valid), 64'd1);
    chk("R6 addr stable", msg_addr, held_a);
    chk("R6 data stable", 64'(msg_data), 64'(held_d));
    take_msg(7, held_a, held_d, "R6 held message");

    // R3 configuration write in the same cycle as the pick
    lo_old = cur_lo; lo_new = 32'h0000_F000;
    wr_tgt(2, (32'd3 << 18) | 32'h022);
    @(negedge clk);
    pend[2] = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = lo_new;
    @(negedge clk); cfg_we = 1'b0;
    chk("R3 same-cycle valid", 64'(msg_valid), 64'd1);
    a1 = exp_addr(lo_old, cur_hi, tmem[2]);
    take_msg(2, a1, 32'h22, "R3 same-cycle old config");
    cur_lo = lo_new;
    pend[2] = 1'b1;
    expect_valid("R3 next valid");
    take_msg(2, exp_addr(cur_lo, cur_hi, tmem[2]), 32'h22, "R3 new config");

    // R8 lock
    hi_lk = (32'd1 << 31) | (32'd2 << 20) | (32'd3 << 12) | 32'h00A;
    wr_cfg(1'b0, 32'h0C00_0000);
    wr_cfg(1'b1, hi_lk);
    wr_cfg(1'b0, 32'h1111_1111);
    wr_cfg(1'b1, 32'h0000_0FFF);
    tw3 = tmem[3];
    pend[3] = 1'b1;
    expect_valid("R8 valid");
    take_msg(3, exp_addr(32'h0C00_0000, hi_lk, tw3), exp_data(tw3), "R8 locked config");

    finish_run();
  end
endmodule